// File: doc/BRIEF.md
# Descriptor Table Register Load/Store Sequencer

This block holds the two descriptor-table pointer registers of a processor core: a global table pointer and an interrupt table pointer, each made of a 16-bit limit and a 32-bit base. On a start strobe it moves one of them between the register and a six-byte image in memory. It does this one byte per cycle over a simple synchronous byte port, least significant byte first. The image holds the limit in bytes 0 and 1 and the base in bytes 2 to 5.

Before any memory access, the sequencer checks the request against the current processor mode, the current privilege level and the operand form. A refused request ends after one cycle with a fault status and does not touch memory. Accepted loads apply the narrow-operand truncation of the base. Stores on the older core generation write ones into the top base byte. The register being loaded changes only in the cycle that completes the transfer.

Top module: `dtab_move_unit`

## Requirements
- R1: After reset both limits read 0xFFFF, both bases read 0, and `busy`, `done` and `mem_req` are low.
- R2: An accepted store writes six bytes, one per cycle, to `opnd_addr`+0 through +5: limit low byte, limit high byte, then base bytes 0 to 3. It raises `done` with status 0 in the cycle after the last byte is presented, with exactly six request cycles.
- R3: When `legacy_gen` is 1, a store writes 0xFF as image byte 5 (base bits 31:24), and the register keeps its own value.
- R4: An accepted load with `wide_op`=1 sets the limit from bytes 0–1 and all 32 base bits from bytes 2–5. The register changes in the cycle in which `done` is high with status 0.
- R5: An accepted load with `wide_op`=0 keeps base bits 23:0 from the image and sets base bits 31:24 to zero.
- R6: A load with `cpu_mode`=2 (virtual-8086) ends with status 1 (general protection, error code zero), makes no memory request, and leaves both registers unchanged.
- R7: A load with `cpu_mode`=1 (protected) or 3 (reserved, treated as protected) and `cur_priv` not 0 ends with status 1. In `cpu_mode`=0 (real), the privilege level is ignored.
- R8: `opnd_is_reg`=1 ends a store or a load with status 2 (undefined opcode) and no memory request. For a load, the status 1 conditions of R6 and R7 take priority.
- R9: A store with a memory operand is accepted in every mode and at every privilege level.
- R10: While a load is in flight, the register outputs keep their old values until the `done` cycle.
- R11: A `start` while `busy` is high is ignored: it causes no extra `done`, no extra memory request and no register change.
- R12: `tbl_sel`=0 selects the global table and 1 selects the interrupt table. The table that is not selected is never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| op_store | input | 1 | 1 = register to memory, 0 = memory to register |
| tbl_sel | input | 1 | 0 = global table, 1 = interrupt table |
| opnd_addr | input | 32 | Byte address of the image |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 reserved |
| cur_priv | input | 2 | Current privilege level |
| opnd_is_reg | input | 1 | Operand is a register, not memory |
| wide_op | input | 1 | 32-bit operand size |
| legacy_gen | input | 1 | Older 16-bit core generation |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after the request |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 general protection, 2 undefined opcode; valid with `done` |
| gtab_limit | output | 16 | Global table limit |
| gtab_base | output | 32 | Global table base |
| itab_limit | output | 16 | Interrupt table limit |
| itab_base | output | 32 | Interrupt table base |

## Verification
The hardest case to reach is a second `start` that arrives in the middle of a load. The driver pulses `start` again, with the other table selected and a store requested, one cycle after the accepted load begins. The scoreboard then confirms three things: exactly one completion, six request cycles, and an unchanged second table. In every cycle of every load, the monitor also compares the register outputs against the last committed values, which shows that a partly assembled base never becomes visible.

// File: rtl/dtab_pkg.sv
package dtab_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_RSVD = 2'd3
  } cpu_mode_t;

  typedef enum logic [1:0] {
    ST_OK = 2'd0,
    ST_GP = 2'd1,
    ST_UD = 2'd2
  } verdict_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_MOVE = 1'b1
  } phase_t;
endpackage

// File: rtl/dtab_access_check.sv
module dtab_access_check #(
  parameter int PRIV_W = 2
) (
  input  logic              is_store,
  input  logic [1:0]        mode,
  input  logic [PRIV_W-1:0] priv,
  input  logic              is_reg,
  output dtab_pkg::verdict_t verdict
);
  import dtab_pkg::*;

  logic in_v86;
  logic guarded;

  assign in_v86  = (cpu_mode_t'(mode) == MODE_V86);
  assign guarded = (cpu_mode_t'(mode) == MODE_PROT) || (cpu_mode_t'(mode) == MODE_RSVD);

  always_comb begin
    verdict = ST_OK;
    if (is_store) begin
      if (is_reg) verdict = ST_UD;
    end else begin
      if (in_v86)                          verdict = ST_GP;
      else if (guarded && (priv != '0))    verdict = ST_GP;
      else if (is_reg)                     verdict = ST_UD;
    end
  end
endmodule

// File: rtl/dtab_regs.sv
module dtab_regs #(
  parameter int LIMIT_W = 16,
  parameter int BASE_W  = 32,
  parameter int NUM_TBL = 2,
  parameter int SEL_W   = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  logic [BASE_W-1:0]  wr_base,
  output logic [LIMIT_W-1:0] limit_o [NUM_TBL],
  output logic [BASE_W-1:0]  base_o  [NUM_TBL]
);
  localparam logic [LIMIT_W-1:0] RST_LIMIT = '1;
  localparam logic [BASE_W-1:0]  RST_BASE  = '0;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(t));
    always_ff @(posedge clk) begin
      if (rst) begin
        limit_o[t] <= RST_LIMIT;
        base_o[t]  <= RST_BASE;
      end else if (hit) begin
        limit_o[t] <= wr_limit;
        base_o[t]  <= wr_base;
      end
    end
  end
endmodule

// File: rtl/dtab_byte_engine.sv
module dtab_byte_engine #(
  parameter int ADDR_W = 32,
  parameter int IMG_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [IMG_W-1:0]  launch_img,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              wr_end,
  output logic              rd_end,
  output logic [IMG_W-1:0]  rd_image
);
  localparam int BYTES = IMG_W / 8;
  localparam int CNT_W = $clog2(BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_ISS = CNT_W'(BYTES);
  localparam logic [CNT_W-1:0] LAST_RX  = CNT_W'(BYTES - 1);

  logic [CNT_W-1:0] iss_q, rx_q;
  logic [IMG_W-1:0] sh_q, asm_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      sh_q      <= '0;
      iss_q     <= '0;
    end else if (launch) begin
      mem_req   <= 1'b1;
      mem_we    <= launch_we;
      mem_addr  <= launch_addr;
      mem_wdata <= launch_img[7:0];
      sh_q      <= launch_img >> 8;
      iss_q     <= CNT_W'(1);
    end else if (mem_req) begin
      if (iss_q == LAST_ISS) begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end else begin
        mem_addr  <= mem_addr + ADDR_W'(1);
        mem_wdata <= sh_q[7:0];
        sh_q      <= sh_q >> 8;
        iss_q     <= iss_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      rx_q   <= '0;
      asm_q  <= '0;
    end else begin
      pend_q <= mem_req && !mem_we;
      if (launch) begin
        rx_q <= '0;
      end else if (pend_q) begin
        asm_q <= rd_image;
        rx_q  <= rx_q + CNT_W'(1);
      end
    end
  end

  assign rd_image = {mem_rdata, asm_q[IMG_W-1:8]};
  assign wr_end   = mem_req && mem_we && (iss_q == LAST_ISS);
  assign rd_end   = pend_q && (rx_q == LAST_RX);
endmodule

// File: rtl/dtab_move_unit.sv
module dtab_move_unit #(
  parameter int ADDR_W   = 32,
  parameter int LIMIT_W  = 16,
  parameter int BASE_W   = 32,
  parameter int NARROW_W = 24,
  parameter int PRIV_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_store,
  input  logic               tbl_sel,
  input  logic [ADDR_W-1:0]  opnd_addr,
  input  logic [1:0]         cpu_mode,
  input  logic [PRIV_W-1:0]  cur_priv,
  input  logic               opnd_is_reg,
  input  logic               wide_op,
  input  logic               legacy_gen,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic [LIMIT_W-1:0] gtab_limit,
  output logic [BASE_W-1:0]  gtab_base,
  output logic [LIMIT_W-1:0] itab_limit,
  output logic [BASE_W-1:0]  itab_base
);
  import dtab_pkg::*;

  localparam int NUM_TBL = 2;
  localparam int IMG_W   = LIMIT_W + BASE_W;
  localparam int TOP_W   = BASE_W - NARROW_W;
  localparam logic [BASE_W-1:0] NARROW_MASK = {{TOP_W{1'b0}}, {NARROW_W{1'b1}}};

  verdict_t           verdict;
  phase_t             phase_q;
  logic               cur_store_q, cur_sel_q, cur_wide_q;
  logic               launch, commit, wr_end, rd_end;
  logic [IMG_W-1:0]   launch_img, rd_image;
  logic [BASE_W-1:0]  src_base, img_base, raw_base, new_base;
  logic [LIMIT_W-1:0] lim_arr  [NUM_TBL];
  logic [BASE_W-1:0]  base_arr [NUM_TBL];

  dtab_access_check #(.PRIV_W(PRIV_W)) u_check (
    .is_store (op_store),
    .mode     (cpu_mode),
    .priv     (cur_priv),
    .is_reg   (opnd_is_reg),
    .verdict  (verdict)
  );

  assign launch   = (phase_q == PH_IDLE) && start && (verdict == ST_OK);
  assign src_base = base_arr[tbl_sel];
  assign img_base = legacy_gen ? {{TOP_W{1'b1}}, src_base[NARROW_W-1:0]} : src_base;
  assign launch_img = {img_base, lim_arr[tbl_sel]};

  dtab_byte_engine #(.ADDR_W(ADDR_W), .IMG_W(IMG_W)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_we   (op_store),
    .launch_addr (opnd_addr),
    .launch_img  (launch_img),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .wr_end      (wr_end),
    .rd_end      (rd_end),
    .rd_image    (rd_image)
  );

  assign raw_base = rd_image[IMG_W-1:LIMIT_W];
  assign new_base = cur_wide_q ? raw_base : (raw_base & NARROW_MASK);
  assign commit   = (phase_q == PH_MOVE) && !cur_store_q && rd_end;

  dtab_regs #(.LIMIT_W(LIMIT_W), .BASE_W(BASE_W), .NUM_TBL(NUM_TBL)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (commit),
    .wr_sel   (cur_sel_q),
    .wr_limit (rd_image[LIMIT_W-1:0]),
    .wr_base  (new_base),
    .limit_o  (lim_arr),
    .base_o   (base_arr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      done        <= 1'b0;
      status      <= ST_OK;
      cur_store_q <= 1'b0;
      cur_sel_q   <= 1'b0;
      cur_wide_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            if (verdict != ST_OK) begin
              done   <= 1'b1;
              status <= verdict;
            end else begin
              phase_q     <= PH_MOVE;
              cur_store_q <= op_store;
              cur_sel_q   <= tbl_sel;
              cur_wide_q  <= wide_op;
            end
          end
        end
        default: begin
          if ((cur_store_q && wr_end) || (!cur_store_q && rd_end)) begin
            done    <= 1'b1;
            status  <= ST_OK;
            phase_q <= PH_IDLE;
          end
        end
      endcase
    end
  end

  assign busy       = (phase_q == PH_MOVE);
  assign gtab_limit = lim_arr[0];
  assign gtab_base  = base_arr[0];
  assign itab_limit = lim_arr[1];
  assign itab_base  = base_arr[1];
endmodule

// File: rtl/dtab_move_unit_chk.sv
module dtab_move_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic [31:0] gtab_base,
  input logic [31:0] itab_base
);
  // R8 R6: refused requests complete without touching memory
  a_r8_fault_no_access: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd0) |-> !mem_req);

  // R2: consecutive byte requests walk up one address at a time
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 32'd1));

  // R2: direction does not flip inside a burst
  a_r2_dir_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_we == $past(mem_we)));

  // R10: register values only move in a completion cycle
  a_r10_gbase_commit: assert property (@(posedge clk) disable iff (rst)
    (gtab_base != $past(gtab_base)) |-> done);

  a_r10_ibase_commit: assert property (@(posedge clk) disable iff (rst)
    (itab_base != $past(itab_base)) |-> done);

  // R11: completion always leaves the unit idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind dtab_move_unit dtab_move_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .gtab_base (gtab_base),
  .itab_base (itab_base)
);

// File: tb/dtab_move_unit_test.sv
`timescale 1ns/1ps
module dtab_move_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_store = 1'b0, tbl_sel = 1'b0;
  logic [31:0] opnd_addr = '0;
  logic [1:0]  cpu_mode = '0, cur_priv = '0;
  logic        opnd_is_reg = 1'b0, wide_op = 1'b0, legacy_gen = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic [15:0] gtab_limit, itab_limit;
  logic [31:0] gtab_base, itab_base;

  always #2.5 clk = ~clk;

  dtab_move_unit uut (
    .clk(clk), .rst(rst), .start(start), .op_store(op_store), .tbl_sel(tbl_sel),
    .opnd_addr(opnd_addr), .cpu_mode(cpu_mode), .cur_priv(cur_priv),
    .opnd_is_reg(opnd_is_reg), .wide_op(wide_op), .legacy_gen(legacy_gen),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .status(status),
    .gtab_limit(gtab_limit), .gtab_base(gtab_base),
    .itab_limit(itab_limit), .itab_base(itab_base)
  );

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  typedef struct {
    string       tag;
    logic [1:0]  st;
    logic [15:0] gl, il;
    logic [31:0] gb, ib;
    bit          chk_mem;
    logic [7:0]  addr;
    logic [47:0] img;
    int          nreq;
  } exp_t;

  exp_t sb_q[$];
  int total = 0, bad = 0, ndone = 0, npush = 0, reqcnt = 0;
  logic [15:0] m_gl = 16'hFFFF, m_il = 16'hFFFF, v_gl = 16'hFFFF, v_il = 16'hFFFF;
  logic [31:0] m_gb = '0, m_ib = '0, v_gb = '0, v_ib = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected items as completions appear
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) reqcnt++;
      if (busy && !done) begin
        chk("R10 gtab held in flight", {gtab_limit, gtab_base}, {v_gl, v_gb});
        chk("R10 itab held in flight", {itab_limit, itab_base}, {v_il, v_ib});
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk("R11 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.tag, " status"}, status, e.st);
          chk({e.tag, " gtab"}, {gtab_limit, gtab_base}, {e.gl, e.gb});
          chk({e.tag, " itab R12"}, {itab_limit, itab_base}, {e.il, e.ib});
          chk({e.tag, " request count"}, reqcnt, e.nreq);
          if (e.chk_mem) begin
            for (int i = 0; i < 6; i++)
              chk({e.tag, " image byte"}, mem[8'(e.addr + i)], e.img[i*8 +: 8]);
          end
          v_gl = e.gl; v_gb = e.gb; v_il = e.il; v_ib = e.ib;
        end
        reqcnt = 0;
        ndone++;
      end
    end
  end

  task automatic preload(input logic [7:0] a, input logic [47:0] img);
    for (int i = 0; i < 6; i++) mem[8'(a + i)] = img[i*8 +: 8];
  endtask

  task automatic run_op(input string tag, input bit st, input bit sel, input logic [7:0] a,
                        input logic [1:0] md, input logic [1:0] pl, input bit rg,
                        input bit wd, input bit lg, input bit poke);
    exp_t e;
    logic [1:0]  v;
    logic [15:0] lim;
    logic [31:0] bs;
    if (st) v = rg ? 2'd2 : 2'd0;
    else if (md == 2'd2) v = 2'd1;
    else if (md != 2'd0 && pl != 2'd0) v = 2'd1;
    else if (rg) v = 2'd2;
    else v = 2'd0;
    e.tag = tag; e.st = v; e.chk_mem = 1'b0; e.addr = a; e.img = '0;
    e.nreq = (v == 2'd0) ? 6 : 0;
    if (v == 2'd0) begin
      if (st) begin
        lim = sel ? m_il : m_gl;
        bs  = sel ? m_ib : m_gb;
        if (lg) bs[31:24] = 8'hFF;
        e.img = {bs, lim};
        e.chk_mem = 1'b1;
      end else begin
        lim = {mem[8'(a + 1)], mem[a]};
        bs  = {mem[8'(a + 5)], mem[8'(a + 4)], mem[8'(a + 3)], mem[8'(a + 2)]};
        if (!wd) bs[31:24] = 8'h00;
        if (sel) begin m_il = lim; m_ib = bs; end
        else     begin m_gl = lim; m_gb = bs; end
      end
    end
    e.gl = m_gl; e.gb = m_gb; e.il = m_il; e.ib = m_ib;
    sb_q.push_back(e);
    npush++;
    @(negedge clk);
    start = 1'b1; op_store = st; tbl_sel = sel; opnd_addr = {24'd0, a};
    cpu_mode = md; cur_priv = pl; opnd_is_reg = rg; wide_op = wd; legacy_gen = lg;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start = 1'b1; op_store = 1'b1; tbl_sel = ~sel; opnd_addr = 32'h0000_00E0;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone < npush) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 gtab reset", {gtab_limit, gtab_base}, {16'hFFFF, 32'h0});
    chk("R1 itab reset", {itab_limit, itab_base}, {16'hFFFF, 32'h0});
    chk("R1 idle outputs", {busy, done, mem_req}, 3'b000);

    preload(8'h10, 48'h9ABC_5678_1234);
    preload(8'h20, 48'h1122_3344_CDEF);
    preload(8'h60, 48'hA1B2_C3D4_0BAD);
    run_op("R4 R7 wide load real cpl3",  1'b0, 1'b0, 8'h10, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R5 R12 narrow load itab",    1'b0, 1'b1, 8'h20, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R2 R9 store v86 cpl3",       1'b1, 1'b0, 8'h40, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R3 legacy store",            1'b1, 1'b0, 8'h50, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op("R6 load v86",                1'b0, 1'b0, 8'h60, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R7 load prot cpl2",          1'b0, 1'b1, 8'h60, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R7 load rsvd cpl1",          1'b0, 1'b0, 8'h60, 2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R8 load reg operand",        1'b0, 1'b0, 8'h60, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op("R8 load v86 reg priority",   1'b0, 1'b0, 8'h60, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op("R8 store reg operand",       1'b1, 1'b1, 8'h70, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op("R11 load with busy poke",    1'b0, 1'b0, 8'h60, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R11 poke wrote nothing", {mem[8'hE0], mem[8'hE1]}, 16'h0000);
    run_op("R12 store itab",             1'b1, 1'b1, 8'h70, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11 queue drained", sb_q.size(), 0);
    finish_run();
  end
endmodule